// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block connects a 32-bit register-style host port to an 8-bit or 16-bit NAND flash bus. The host address has two windows. In the data window, address bits choose the kind of NAND cycle: bit 4 makes it a command cycle and bit 3 makes it an address cycle. The bits above the cycle-kind bits pick one of up to four core chipselects, and a programmable mask over the window bits drives a die-select line for packages that hold more than one die. Each 32-bit host access is split into back-to-back narrow NAND cycles, lowest byte lane first. On reads, the bytes that come back are packed into the 32-bit read data. The host sees a single acknowledge pulse once the last narrow cycle has finished.

In the register window there are four registers: a per-chipselect NAND-mode enable, a ready status, the strobe timing, and the die-select mask. Software polls the ready bit to see when the shared wired-AND busy line of the attached devices has been released. The bridge has no knowledge of the flash command set. It only sequences the strobes.

Top module: `nand_bus_bridge`

## Requirements
- R1: A data-window access with address bit 4 set drives `nand_cle` high and `nand_ale` low through every narrow cycle of that access.
- R2: With bit 4 clear and bit 3 set, `nand_ale` is high and `nand_cle` is low. With both bits clear, both lines are low. `nand_cle` and `nand_ale` are never high together.
- R3: Address bits [1:0] have no effect on a data-window access. The cycle kind, the number of cycles and the data are the same for all four values.
- R4: A write is issued as 32/DW write-strobe cycles. Byte lane k of the write data (bits [k*DW+DW-1:k*DW]) is on `nand_dq_out` during cycle k, with `nand_dq_oe` high. The data stays stable while `nand_we_n` is low.
- R5: A read is issued as 32/DW read-strobe cycles. The value sampled on `nand_dq_in` at the end of cycle k goes to lane k of `host_rdata`, which is valid together with `host_ack`. `nand_dq_oe` is low during reads.
- R6: Window address bits [14:13] select core chipselect c. Only `nand_ce_n[c]` is driven low during the access, and all enables are high when idle. If bit c of the mode-enable register is 0, no strobe occurs, the access is acknowledged after one cycle, and reads return 0.
- R7: `nand_die_sel` is high during the cycles of an access when the window address ANDed with the die mask is nonzero, and low otherwise.
- R8: Status register bit 0 equals `nand_wait` after a two-flop synchronizer. It is 0 while any device is busy.
- R9: Timing register field [3:0] sets the setup length, [7:4] the strobe low width, and [11:8] the hold length, in cycles, with a field value of 0 treated as 1. A data access acknowledges (32/DW)*(S+P+H)+1 cycles after it is accepted.
- R10: `host_ack` is a single-cycle pulse. The write and read strobes are never low together. A register access is acknowledged one cycle after it is accepted.
- R11: Register window (address bit 15 set, register selected by bits [3:2]): 0 mode-enable [3:0], 1 status, 2 timing [11:0], 3 die mask [14:0]. All reset to 0 and read back what was written. Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| host_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | N_CS | Per-chipselect chip enable, active low |
| nand_die_sel | output | 1 | Secondary die select |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DW | Data driven to flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | DW | Data returned by flash |
| nand_wait | input | 1 | Wired-AND ready line, low when busy |

## Verification
On every cycle, the embedded properties check that the two strobes never overlap, that CLE and ALE are mutually exclusive, that at most one chip enable is active and is active under any strobe, that the write data is held during the write pulse, that the data bus is released during reads, and that the acknowledge is a single pulse. The arithmetic sweeps in the bench cover the rest. These include the cycle-count formula for every small timing setting, the little-endian lane order on writes and reads, the cycle kind for each combination of address bits 4, 3, 1 and 0, per-chipselect enable masking, the die mask, and the synchronized ready bit.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam int TCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_ACK
  } seq_state_e;

  typedef enum logic [1:0] {
    CYC_DATA,
    CYC_ADDR,
    CYC_CMD
  } cyc_kind_e;

  typedef struct packed {
    logic [TCNT_W-1:0] hold;
    logic [TCNT_W-1:0] pulse;
    logic [TCNT_W-1:0] setup;
  } nbb_timing_t;

  localparam int TIMING_W = $bits(nbb_timing_t);

endpackage

// File: rtl/nbb_decode.sv
module nbb_decode
  import nbb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_CS   = 4,
  parameter int CS_LSB = 13,
  parameter int CS_W   = 2
) (
  input  logic [ADDR_W-1:0] haddr,
  input  logic [N_CS-1:0]   cs_en,
  input  logic [ADDR_W-2:0] die_mask,
  output logic              is_reg,
  output logic [1:0]        reg_idx,
  output logic [CS_W-1:0]   cs_idx,
  output logic              cs_ok,
  output cyc_kind_e         kind,
  output logic              die_hit
);

  logic [N_CS-1:0] cs_hit;

  assign is_reg  = haddr[ADDR_W-1];
  assign reg_idx = haddr[3:2];
  assign cs_idx  = haddr[CS_LSB +: CS_W];

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign cs_hit[g] = (cs_idx == CS_W'(g)) && cs_en[g];
  end

  assign cs_ok   = |cs_hit;
  assign die_hit = |(haddr[ADDR_W-2:0] & die_mask);

  always_comb begin
    if (haddr[4])      kind = CYC_CMD;
    else if (haddr[3]) kind = CYC_ADDR;
    else               kind = CYC_DATA;
  end

endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
#(
  parameter int N_CS  = 4,
  parameter int REG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       idx,
  input  logic [REG_W-1:0] wdata,
  input  logic             nand_wait,
  output logic [N_CS-1:0]  cs_en,
  output nbb_timing_t      timing,
  output logic [REG_W-1:0] die_mask,
  output logic [31:0]      rdata,
  output logic             ready
);

  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_STATUS = 2'd1;
  localparam logic [1:0] IDX_TIMING = 2'd2;
  localparam logic [1:0] IDX_MASK   = 2'd3;

  logic [N_CS-1:0]  cs_en_d;
  nbb_timing_t      timing_d;
  logic [REG_W-1:0] die_mask_d;
  logic [31:0]      rdata_d;
  logic             wait_meta_q;
  logic             ready_q;

  always_comb begin
    cs_en_d    = cs_en;
    timing_d   = timing;
    die_mask_d = die_mask;
    rdata_d    = rdata;
    if (wr_en) begin
      case (idx)
        IDX_CTRL:   cs_en_d    = wdata[N_CS-1:0];
        IDX_TIMING: timing_d   = nbb_timing_t'(wdata[TIMING_W-1:0]);
        IDX_MASK:   die_mask_d = wdata;
        default:    ;
      endcase
    end
    if (rd_en) begin
      case (idx)
        IDX_CTRL:   rdata_d = 32'(cs_en);
        IDX_STATUS: rdata_d = 32'(ready_q);
        IDX_TIMING: rdata_d = 32'(timing);
        default:    rdata_d = 32'(die_mask);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en    <= '0;
      timing   <= '0;
      die_mask <= '0;
      rdata    <= '0;
    end else begin
      cs_en    <= cs_en_d;
      timing   <= timing_d;
      die_mask <= die_mask_d;
      rdata    <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_meta_q <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      wait_meta_q <= nand_wait;
      ready_q     <= wait_meta_q;
    end
  end

  assign ready = ready_q;

  // R11: configuration only moves on a register write
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cs_en) && $stable(timing) && $stable(die_mask));

  // R8: the status bit lags the wait pin by exactly two edges
  a_r8_ready_lag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nand_wait) == nand_wait) && $past(wait_meta_q) == $past(nand_wait)
      |=> ready == $past(nand_wait));

endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int N_CS = 4,
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic            is_reg,
  input  logic            cs_ok,
  input  logic [CS_W-1:0] cs_idx,
  input  cyc_kind_e       kind,
  input  logic            die_hit,
  input  logic [31:0]     wdata,
  input  nbb_timing_t     timing,
  input  logic [DW-1:0]   dq_in,
  output logic            accept,
  output logic            ack,
  output logic [31:0]     rdata,
  output logic [N_CS-1:0] ce_n,
  output logic            die_sel,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe
);

  localparam int BEATS  = 32 / DW;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [TCNT_W-1:0] ONE       = TCNT_W'(1);

  function automatic logic [TCNT_W-1:0] floor_one(input logic [TCNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  seq_state_e        state_q, state_d;
  logic [TCNT_W-1:0] cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [TCNT_W-1:0] len_setup, len_pulse, len_hold;
  logic              capture;
  logic              active;

  logic              wr_q;
  cyc_kind_e         kind_q;
  logic [CS_W-1:0]   cs_q;
  logic              die_q;
  logic [31:0]       wdata_q;

  assign len_setup = floor_one(timing.setup);
  assign len_pulse = floor_one(timing.pulse);
  assign len_hold  = floor_one(timing.hold);

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    accept  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          cnt_d   = ONE;
          beat_d  = '0;
          state_d = (!is_reg && cs_ok) ? ST_SETUP : ST_ACK;
        end
      end
      ST_SETUP: begin
        if (cnt_q == len_setup) begin
          state_d = ST_STROBE;
          cnt_d   = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_STROBE: begin
        if (cnt_q == len_pulse) begin
          state_d = ST_HOLD;
          cnt_d   = ONE;
          capture = !wr_q;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_HOLD: begin
        if (cnt_q == len_hold) begin
          cnt_d = ONE;
          if (beat_q == LAST_BEAT) begin
            state_d = ST_ACK;
          end else begin
            beat_d  = beat_q + BEAT_W'(1);
            state_d = ST_SETUP;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= ONE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
    end
  end

  // access context, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      kind_q  <= CYC_DATA;
      cs_q    <= '0;
      die_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= we;
      kind_q  <= kind;
      cs_q    <= cs_idx;
      die_q   <= die_hit;
      wdata_q <= wdata;
    end
  end

  // one capture register per read lane
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (accept) begin
        lane_q <= '0;
      end else if (capture && beat_q == BEAT_W'(g)) begin
        lane_q <= dq_in;
      end
    end
    assign rdata[g*DW +: DW] = lane_q;
  end

  // pin outputs from registered state
  assign active  = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign ack     = (state_q == ST_ACK);
  assign cle     = active && (kind_q == CYC_CMD);
  assign ale     = active && (kind_q == CYC_ADDR);
  assign die_sel = active && die_q;
  assign we_n    = !((state_q == ST_STROBE) && wr_q);
  assign re_n    = !((state_q == ST_STROBE) && !wr_q);
  assign dq_oe   = active && wr_q;
  assign dq_out  = wdata_q[beat_q*DW +: DW];

  always_comb begin
    ce_n = '1;
    if (active) ce_n[cs_q] = 1'b0;
  end

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r2_cle_ale_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r6_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));

  a_r6_strobe_under_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> (ce_n != '1));

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq_out));

  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 8,
  parameter int N_CS   = 4,
  parameter int CS_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_ack,
  output logic [N_CS-1:0]   nand_ce_n,
  output logic              nand_die_sel,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DW-1:0]     nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DW-1:0]     nand_dq_in,
  input  logic              nand_wait
);

  localparam int CS_W  = (N_CS > 1) ? $clog2(N_CS) : 1;
  localparam int REG_W = ADDR_W - 1;

  logic        rst_meta_q, rst_core_n;
  logic        is_reg, cs_ok, die_hit, accept, rsel_q, ready;
  logic [1:0]  reg_idx;
  logic [CS_W-1:0] cs_idx;
  cyc_kind_e   kind;
  logic [N_CS-1:0]  cs_en;
  logic [REG_W-1:0] die_mask;
  nbb_timing_t timing;
  logic [31:0] reg_rdata, seq_rdata;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  nbb_decode #(
    .ADDR_W(ADDR_W), .N_CS(N_CS), .CS_LSB(CS_LSB), .CS_W(CS_W)
  ) i_decode (
    .haddr(host_addr), .cs_en(cs_en), .die_mask(die_mask),
    .is_reg(is_reg), .reg_idx(reg_idx), .cs_idx(cs_idx), .cs_ok(cs_ok),
    .kind(kind), .die_hit(die_hit)
  );

  nbb_regs #(
    .N_CS(N_CS), .REG_W(REG_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(accept && is_reg && host_we),
    .rd_en(accept && is_reg && !host_we),
    .idx(reg_idx), .wdata(host_wdata[REG_W-1:0]), .nand_wait(nand_wait),
    .cs_en(cs_en), .timing(timing), .die_mask(die_mask),
    .rdata(reg_rdata), .ready(ready)
  );

  nbb_seq #(
    .DW(DW), .N_CS(N_CS), .CS_W(CS_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_core_n),
    .req(host_req), .we(host_we), .is_reg(is_reg), .cs_ok(cs_ok),
    .cs_idx(cs_idx), .kind(kind), .die_hit(die_hit), .wdata(host_wdata),
    .timing(timing), .dq_in(nand_dq_in),
    .accept(accept), .ack(host_ack), .rdata(seq_rdata),
    .ce_n(nand_ce_n), .die_sel(nand_die_sel), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rsel_q <= 1'b0;
    else if (accept)  rsel_q <= is_reg;
  end

  assign host_rdata = rsel_q ? reg_rdata : seq_rdata;

  // R10: a register access never drives a strobe
  a_r10_reg_no_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && is_reg) |=> nand_we_n && nand_re_n && host_ack);

  // R8: status bit is defined after reset
  a_r8_ready_known: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$isunknown(ready));

endmodule

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;

  localparam int DW    = 8;
  localparam int BEATS = 32 / DW;
  localparam logic [15:0] R_CTRL   = 16'h8000;
  localparam logic [15:0] R_STATUS = 16'h8004;
  localparam logic [15:0] R_TIMING = 16'h8008;
  localparam logic [15:0] R_MASK   = 16'h800C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ack;
  logic [3:0]  nand_ce_n;
  logic        nand_die_sel, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [DW-1:0] nand_dq_out;
  logic [DW-1:0] nand_dq_in = '0;
  logic        nand_wait = 1'b1;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  nand_bus_bridge i_nand_bus_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
    .nand_ce_n(nand_ce_n), .nand_die_sel(nand_die_sel), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_wait(nand_wait)
  );

  // flash-side monitor: records each write beat and answers read beats
  int         wn = 0;
  int         rn = 0;
  logic [7:0] w_dat [2048];
  logic       w_cle [2048];
  logic       w_ale [2048];
  logic       w_die [2048];
  logic       w_oe  [2048];
  logic [3:0] w_ce  [2048];
  int         w_run [2048];
  logic [3:0] r_ce  [2048];
  logic       r_oe  [2048];
  int         r_run [2048];

  function automatic logic [7:0] rd_val(input int i);
    return 8'((i * 37 + 90) & 255);
  endfunction

  initial begin
    logic pwe = 1'b1;
    logic pre = 1'b1;
    int   wrun = 0;
    int   rrun = 0;
    forever begin
      @(negedge clk);
      if (!nand_we_n) wrun++;
      if (pwe == 1'b0 && nand_we_n == 1'b1) begin
        w_dat[wn] = nand_dq_out; w_cle[wn] = nand_cle; w_ale[wn] = nand_ale;
        w_die[wn] = nand_die_sel; w_oe[wn] = nand_dq_oe; w_ce[wn] = nand_ce_n;
        w_run[wn] = wrun; wrun = 0; wn++;
      end
      if (pre == 1'b1 && nand_re_n == 1'b0) begin
        nand_dq_in = rd_val(rn);
        r_ce[rn] = nand_ce_n; r_oe[rn] = nand_dq_oe;
      end
      if (!nand_re_n) rrun++;
      if (pre == 1'b0 && nand_re_n == 1'b1) begin
        r_run[rn] = rrun; rrun = 0; rn++;
      end
      pwe = nand_we_n;
      pre = nand_re_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [15:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ack && lat < 2000);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  function automatic int m1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp;
    int lat, n0, r0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R10, R11)
    chk("R6 idle enables", 32'(nand_ce_n), 32'hF);
    chk("R10 idle strobes", {30'd0, nand_we_n, nand_re_n}, 32'h3);
    chk("R1 idle cle/ale", {30'd0, nand_cle, nand_ale}, 32'h0);
    acc(1'b0, R_CTRL, '0, rd, lat);   chk("R11 ctrl reset", rd, 32'h0);
    chk("R10 reg ack latency", 32'(lat), 32'd1);
    acc(1'b0, R_TIMING, '0, rd, lat); chk("R11 timing reset", rd, 32'h0);
    acc(1'b0, R_MASK, '0, rd, lat);   chk("R11 mask reset", rd, 32'h0);

    // R8 ready status
    acc(1'b0, R_STATUS, '0, rd, lat); chk("R8 ready high", rd, 32'h1);
    @(negedge clk); nand_wait = 1'b0; repeat (3) @(negedge clk);
    acc(1'b0, R_STATUS, '0, rd, lat); chk("R8 ready low while busy", rd, 32'h0);
    acc(1'b1, R_STATUS, 32'hFFFF, rd, lat);
    acc(1'b0, R_STATUS, '0, rd, lat); chk("R11 status write ignored", rd, 32'h0);
    @(negedge clk); nand_wait = 1'b1; repeat (3) @(negedge clk);
    acc(1'b0, R_STATUS, '0, rd, lat); chk("R8 ready restored", rd, 32'h1);

    // R6 disabled chipselect: no strobes, quick ack, read zero
    n0 = wn; r0 = rn;
    acc(1'b1, 16'h0010, 32'hDEADBEEF, rd, lat);
    chk("R6 disabled write latency", 32'(lat), 32'd1);
    chk("R6 disabled write beats", 32'(wn - n0), 32'd0);
    acc(1'b0, 16'h0000, '0, rd, lat);
    chk("R6 disabled read data", rd, 32'h0);
    chk("R6 disabled read beats", 32'(rn - r0), 32'd0);

    // R11 readback
    acc(1'b1, R_CTRL, 32'h0000_000F, rd, lat);
    acc(1'b0, R_CTRL, '0, rd, lat); chk("R11 ctrl readback", rd, 32'hF);
    acc(1'b1, R_MASK, 32'h0000_1000, rd, lat);
    acc(1'b0, R_MASK, '0, rd, lat); chk("R11 mask readback", rd, 32'h1000);

    // R9/R4 timing sweep with writes over all chipselects
    for (int su = 0; su < 4; su++)
      for (int pw = 0; pw < 4; pw++)
        for (int hd = 0; hd < 4; hd++) begin
          logic [31:0] wd;
          int cs;
          cs = (su + pw + hd) % 4;
          wd = {8'(su * 16 + pw), 8'(hd + 8'hA0), 8'(cs + 8'h30), 8'(su ^ pw ^ hd)};
          acc(1'b1, R_TIMING, 32'(hd * 256 + pw * 16 + su), rd, lat);
          acc(1'b0, R_TIMING, '0, rd, lat);
          chk("R11 timing readback", rd, 32'(hd * 256 + pw * 16 + su));
          n0 = wn;
          acc(1'b1, 16'(cs << 13), wd, rd, lat);
          chk("R9 write latency", 32'(lat), 32'(BEATS * (m1(su) + m1(pw) + m1(hd)) + 1));
          chk("R4 write beat count", 32'(wn - n0), 32'(BEATS));
          chk("R4 little-endian lanes",
              {w_dat[n0+3], w_dat[n0+2], w_dat[n0+1], w_dat[n0]}, wd);
          chk("R9 strobe width", 32'(w_run[n0]), 32'(m1(pw)));
          chk("R6 selected enable", 32'(w_ce[n0]), 32'(~(4'b1 << cs) & 4'hF));
          chk("R4 output enable", 32'(w_oe[n0] & w_oe[n0+3]), 32'h1);
        end

    // R1/R2/R3 cycle-kind sweep over bits 4,3 and the ignored bits 1,0
    acc(1'b1, R_TIMING, 32'h0000_0111, rd, lat);
    for (int k = 0; k < 4; k++)
      for (int lo = 0; lo < 4; lo++) begin
        logic ecle, eale;
        ecle = k[1];
        eale = k[0] & ~k[1];
        n0 = wn;
        acc(1'b1, 16'((k << 3) | lo), 32'h4433_2211, rd, lat);
        chk("R3 beats independent of low bits", 32'(wn - n0), 32'(BEATS));
        chk("R3 data independent of low bits",
            {w_dat[n0+3], w_dat[n0+2], w_dat[n0+1], w_dat[n0]}, 32'h4433_2211);
        chk(ecle ? "R1 command cycle" : "R2 cycle kind",
            {30'd0, w_cle[n0] & w_cle[n0+3], w_ale[n0] & w_ale[n0+3]},
            {30'd0, ecle, eale});
        chk("R2 kind on middle beats", {30'd0, w_cle[n0+1] | w_cle[n0+2], w_ale[n0+1] | w_ale[n0+2]},
            {30'd0, ecle, eale});
      end

    // R5 read assembly on each chipselect
    acc(1'b1, R_TIMING, 32'h0000_0132, rd, lat);
    for (int cs = 0; cs < 4; cs++) begin
      r0 = rn;
      acc(1'b0, 16'((cs << 13) | 3), '0, rd, lat);
      exp = {rd_val(r0 + 3), rd_val(r0 + 2), rd_val(r0 + 1), rd_val(r0)};
      chk("R5 read data lanes", rd, exp);
      chk("R5 read beat count", 32'(rn - r0), 32'(BEATS));
      chk("R5 bus released", 32'(r_oe[r0]), 32'h0);
      chk("R9 read strobe width", 32'(r_run[r0]), 32'd3);
      chk("R9 read latency", 32'(lat), 32'(BEATS * 6 + 1));
      chk("R6 read enable", 32'(r_ce[r0]), 32'(~(4'b1 << cs) & 4'hF));
    end

    // R7 die select through mask bit 12
    n0 = wn;
    acc(1'b1, 16'h1000, 32'h0, rd, lat);
    chk("R7 die select on", 32'(w_die[n0] & w_die[n0+3]), 32'h1);
    n0 = wn;
    acc(1'b1, 16'h0800, 32'h0, rd, lat);
    chk("R7 die select off", 32'(w_die[n0] | w_die[n0+3]), 32'h0);
    @(negedge clk);
    chk("R7 die idle low", 32'(nand_die_sel), 32'h0);

    // R6 partial enable mask
    acc(1'b1, R_CTRL, 32'h0000_0005, rd, lat);
    for (int cs = 0; cs < 4; cs++) begin
      n0 = wn;
      acc(1'b1, 16'(cs << 13), 32'h0102_0304, rd, lat);
      chk("R6 per-chipselect enable", 32'(wn - n0), (cs % 2 == 0) ? 32'(BEATS) : 32'd0);
      chk("R10 latency by enable", 32'(lat), (cs % 2 == 0) ? 32'(BEATS * 6 + 1) : 32'd1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule